// File: doc/BRIEF.md
# Bit-Serial ARX Feistel Encryptor

This block encrypts one 64-bit block made of eight 8-bit words with an add-rotate-XOR Feistel cipher. Its datapath is one bit wide. The text sits in a 64-bit ring that shifts by one position on every clock. One bit is written back per cycle, and it is computed from the bit leaving the head of the ring.

A full encryption runs as 34 windows of 64 cycles: an initial whitening window, 32 rounds, and a final whitening window. Each window is 8 steps of 8 cycles, and each step handles one byte, least significant bit first.

The bytewise word rotation between rounds is never carried out physically. Instead, the label of the byte that reaches the head at a window start advances by one each round. A one-byte capture register records the byte written in the previous step, and a rotating copy of it produces the mixing-function output one bit at a time. A single carry flip-flop serves every serial addition.

An external key unit supplies one subkey bit and one whitening-key bit per cycle, following the fixed schedule given in R6. Plaintext is loaded serially, and the ciphertext is read serially after the one-cycle done pulse.

Top module: `serial_arx_enc`

## Requirements
- R1: After reset, done_o is low and dout_o reads 0, because the text ring is cleared.
- R2: While load_i is high and no encryption is running, each clock shifts din_i into the ring. Over 64 consecutive load cycles, plaintext bit 8j+b (byte j, bit b) is taken in load cycle 8j+b. The 64-cycle phase counter reads 0 in the first cycle after the last load cycle.
- R3: A start_i pulse while idle is a request. Encryption begins in the first cycle, at or after the request, in which the phase is 0, that is, a whole number of 64-cycle periods after the last load cycle. A request made at phase 0 begins at once.
- R4: An encryption occupies 2176 consecutive cycles. done_o is high for exactly one cycle, 2176 cycles after the first encryption cycle.
- R5: dout_o presents ciphertext bit 8j+b in cycle D+8j+b, where D is the done cycle. While load_i stays low, the same 64-bit pattern repeats every 64 cycles.
- R6: Encryption cycle c is split as c = 64w + 8s + b. The byte label is j = (base + s) mod 8, where base is 0 for w = 0, (w-1) mod 8 for w = 1..32, and 7 for w = 33. When w is 0 and j is even, wk_i carries bit b of WK[j/2]. When w is 33 and j is even, wk_i carries bit b of WK[4+j/2]. When w is 1..32 and j is odd, rk_i carries bit b of SK[4(w-1)+(j-1)/2]. In all other cycles both key inputs are ignored.
- R7: The initial transformation sets X0 = X0+WK0, X2 = X2^WK1, X4 = X4+WK2 and X6 = X6^WK3, and leaves the odd bytes unchanged.
- R8: Round r updates the odd bytes. Bytes 1 and 5 follow X + (G(Xprev) ^ SK). Bytes 3 and 7 follow X ^ (H(Xprev) + SK). Here Xprev is the byte just below, G(x) = rotl3^rotl4^rotl6 and H(x) = rotl1^rotl2^rotl7, all on 8-bit values. The subkeys for bytes 1, 3, 5 and 7 are SK[4r], SK[4r+1], SK[4r+2] and SK[4r+3].
- R9: After each of rounds 0..30, the new byte k+1 is the old byte k and the new byte 0 is the updated byte 7. Round 31 leaves the byte order as it is.
- R10: The final transformation applies the R7 pattern with WK4..WK7.
- R11: Every addition is modulo 256. No carry passes between bytes or between windows.
- R12: start_i asserted during an encryption has no effect: it produces no second done pulse and leaves no pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Shift din_i into the text ring while idle |
| din_i | input | 1 | Serial plaintext bit |
| start_i | input | 1 | Encryption request |
| rk_i | input | 1 | Serial round-subkey bit |
| wk_i | input | 1 | Serial whitening-key bit |
| dout_o | output | 1 | Serial ciphertext bit |
| done_o | output | 1 | One-cycle pulse marking valid ciphertext |

## Verification
Counted from the first encryption cycle, done_o is due 2176 cycles later. Ciphertext bit i is due i cycles after that, and the same bit is due again 64 cycles after that. The first encryption cycle is not the start pulse itself. The bench works it out by counting its own 64-cycle phase from the end of loading, so a delayed start is credited with the correct wait before the run begins. The driver drives the key bit for every encryption cycle on the falling edge of that cycle, using the R6 schedule, and pushes the expected ciphertext and done cycle into a queue. The monitor samples on falling edges, compares the done cycle exactly, and then compares two full 64-bit output passes.

// File: rtl/serial_arx_enc.sv
module serial_arx_enc #(
  parameter int ROUNDS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic din_i,
  input  logic start_i,
  input  logic rk_i,
  input  logic wk_i,
  output logic dout_o,
  output logic done_o
);
  localparam int NBIT = 64;
  localparam int LAST = ROUNDS + 1;
  localparam int WW   = $clog2(ROUNDS + 2);

  logic [NBIT-1:0] ring;
  logic [7:0]      cap, fr, src;
  logic [5:0]      cnt;
  logic [WW-1:0]   win;
  logic            cy, cnext, cin, run, pend, wbit, ta, tb, f0, f1;
  logic            go, act, xform, endwin;
  logic [2:0]      base, j;

  wire h = ring[0];

  assign go     = !run && !load_i && (start_i || pend) && (cnt == 6'd0);
  assign act    = run || go;
  assign xform  = (win == '0) || (win == WW'(LAST));
  assign endwin = act && (cnt == 6'd63);
  assign dout_o = ring[8];

  always_comb begin
    if (win == '0)               base = 3'd0;
    else if (win == WW'(LAST))   base = 3'((ROUNDS - 1) % 8);
    else                         base = 3'(win - WW'(1));
  end
  assign j = base + cnt[5:3];

  assign src = (cnt[2:0] == 3'd0) ? cap : fr;
  assign f1  = src[5] ^ src[4] ^ src[2];
  assign f0  = src[7] ^ src[6] ^ src[1];
  assign cin = (cnt[2:0] == 3'd0) ? 1'b0 : cy;

  always_comb begin
    ta    = f1 ^ rk_i;
    tb    = f0 ^ rk_i ^ cin;
    wbit  = h;
    cnext = 1'b0;
    if (!act) begin
      wbit = load_i ? din_i : h;
    end else if (xform) begin
      if (!j[0] && !j[1]) begin
        wbit  = h ^ wk_i ^ cin;
        cnext = (h & wk_i) | (h & cin) | (wk_i & cin);
      end else if (!j[0]) begin
        wbit = h ^ wk_i;
      end
    end else if (j[0] && !j[1]) begin
      wbit  = h ^ ta ^ cin;
      cnext = (h & ta) | (h & cin) | (ta & cin);
    end else if (j[0]) begin
      wbit  = h ^ tb;
      cnext = (f0 & rk_i) | (f0 & cin) | (rk_i & cin);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring   <= '0;
      cap    <= '0;
      fr     <= '0;
      cy     <= 1'b0;
      cnt    <= '0;
      win    <= '0;
      run    <= 1'b0;
      pend   <= 1'b0;
      done_o <= 1'b0;
    end else begin
      ring   <= {wbit, ring[NBIT-1:1]};
      cap    <= {wbit, cap[7:1]};
      fr     <= {src[0], src[7:1]};
      cy     <= cnext;
      cnt    <= (!act && load_i) ? 6'd0 : cnt + 6'd1;
      done_o <= endwin && (win == WW'(LAST));
      if (endwin) win <= (win == WW'(LAST)) ? '0 : win + WW'(1);
      if (go) run <= 1'b1;
      else if (endwin && win == WW'(LAST)) run <= 1'b0;
      if (go || run) pend <= 1'b0;
      else if (start_i) pend <= 1'b1;
    end
  end
endmodule

// File: rtl/serial_arx_enc_chk.sv
module serial_arx_enc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       load_i,
  input logic       done_o,
  input logic       run,
  input logic       pend,
  input logic [5:0] cnt
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R4
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!run && $past(run))); // R4
  AST_RUN_AT_PHASE0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> ($past(cnt) == 6'd0)); // R3
  AST_NO_PEND_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !run); // R12
  AST_LOAD_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(load_i) && !$past(run)) |-> (cnt == 6'd0)); // R2
endmodule

bind serial_arx_enc serial_arx_enc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load_i(load_i), .done_o(done_o),
  .run(run), .pend(pend), .cnt(cnt)
);

// File: tb/test_serial_arx_enc.sv
module test_serial_arx_enc;
  logic clk = 1'b0, rst_n = 1'b0, load_i = 1'b0, din_i = 1'b0;
  logic start_i = 1'b0, rk_i = 1'b0, wk_i = 1'b0;
  wire  dout_o, done_o;

  always #4 clk = ~clk;

  serial_arx_enc i_serial_arx_enc (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .din_i(din_i), .start_i(start_i),
    .rk_i(rk_i), .wk_i(wk_i), .dout_o(dout_o), .done_o(done_o)
  );

  typedef struct { logic [63:0] ct; int due; } exp_t;
  exp_t sb[$];
  int cyc = 0, n_chk = 0, n_fail = 0, n_done = 0, n_runs = 0;
  logic [7:0] wk [8];
  logic [7:0] sk [128];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] a, input logic [63:0] e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  function automatic logic [7:0] rl8(input logic [7:0] x, input int n);
    return (x << n) | (x >> (8 - n));
  endfunction
  function automatic logic [7:0] fg(input logic [7:0] x);
    return rl8(x, 3) ^ rl8(x, 4) ^ rl8(x, 6);
  endfunction
  function automatic logic [7:0] fh(input logic [7:0] x);
    return rl8(x, 1) ^ rl8(x, 2) ^ rl8(x, 7);
  endfunction

  function automatic logic [63:0] model(input logic [63:0] p);
    logic [7:0] x [8];
    logic [7:0] y [8];
    logic [7:0] n1, n3, n5, n7;
    logic [63:0] res;
    for (int k = 0; k < 8; k++) x[k] = p[8*k +: 8];
    x[0] = x[0] + wk[0]; x[2] = x[2] ^ wk[1]; x[4] = x[4] + wk[2]; x[6] = x[6] ^ wk[3];
    for (int r = 0; r < 32; r++) begin
      n1 = x[1] + (fg(x[0]) ^ sk[4*r]);
      n3 = x[3] ^ (fh(x[2]) + sk[4*r+1]);
      n5 = x[5] + (fg(x[4]) ^ sk[4*r+2]);
      n7 = x[7] ^ (fh(x[6]) + sk[4*r+3]);
      if (r < 31) begin
        y[0] = n7; y[1] = x[0]; y[2] = n1; y[3] = x[2];
        y[4] = n3; y[5] = x[4]; y[6] = n5; y[7] = x[6];
      end else begin
        y[0] = x[0]; y[1] = n1; y[2] = x[2]; y[3] = n3;
        y[4] = x[4]; y[5] = n5; y[6] = x[6]; y[7] = n7;
      end
      for (int k = 0; k < 8; k++) x[k] = y[k];
    end
    x[0] = x[0] + wk[4]; x[2] = x[2] ^ wk[5]; x[4] = x[4] + wk[6]; x[6] = x[6] ^ wk[7];
    for (int k = 0; k < 8; k++) res[8*k +: 8] = x[k];
    return res;
  endfunction

  // R6 key schedule per encryption cycle
  task automatic drive_keys(input int c);
    int w, s, b, base, j;
    w = c / 64; s = (c / 8) % 8; b = c % 8;
    base = (w == 0) ? 0 : (w == 33) ? 7 : ((w - 1) % 8);
    j = (base + s) % 8;
    rk_i = 1'b0; wk_i = 1'b0;
    if (w == 0 || w == 33) begin
      if (j % 2 == 0) wk_i = wk[((w == 33) ? 4 : 0) + j / 2][b];
    end else if (j % 2 == 1) begin
      rk_i = sk[4*(w-1) + (j-1)/2][b];
    end
  endtask

  task automatic run_enc(input logic [63:0] p, input int delay, input bit glitch);
    exp_t it;
    int ph;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); load_i = 1'b1; din_i = p[i];
    end
    @(negedge clk); load_i = 1'b0; din_i = 1'b0; ph = 0;
    repeat (delay) begin @(negedge clk); ph++; end
    start_i = 1'b1;
    if (ph % 64 != 0) begin
      @(negedge clk); start_i = 1'b0; ph++;
      while (ph % 64 != 0) begin @(negedge clk); ph++; end
    end
    it.ct = model(p);
    it.due = cyc + 2176;
    sb.push_back(it);
    n_runs++;
    for (int c = 0; c < 2176; c++) begin
      drive_keys(c);
      if (glitch && c == 1000) start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    rk_i = 1'b0; wk_i = 1'b0;
    repeat (200) @(negedge clk);
  endtask

  task automatic fill_keys(input int mode);
    for (int i = 0; i < 8; i++) wk[i] = (mode == 0) ? 8'h00 : (mode == 1) ? 8'hFF : 8'($urandom);
    for (int i = 0; i < 128; i++) sk[i] = (mode == 0) ? 8'h00 : (mode == 1) ? 8'hFF : 8'($urandom);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // monitor
  initial begin
    exp_t it;
    logic [63:0] got, got2;
    bit extra;
    forever begin
      @(negedge clk);
      if (rst_n && done_o) begin
        n_done++;
        if (sb.size() == 0) begin
          chk(1'b0, "R12 unexpected done", 64'(cyc), 64'd0);
        end else begin
          it = sb.pop_front();
          chk(cyc == it.due, "R4 done cycle", 64'(cyc), 64'(it.due));
          extra = 1'b0;
          for (int i = 0; i < 64; i++) begin
            got[i] = dout_o;
            @(negedge clk);
            if (done_o) extra = 1'b1;
          end
          chk(got == it.ct, "R5/R6/R7/R8/R9/R10/R11 ciphertext", got, it.ct);
          for (int i = 0; i < 64; i++) begin
            got2[i] = dout_o;
            @(negedge clk);
            if (done_o) extra = 1'b1;
          end
          chk(got2 == it.ct, "R5 circulation repeat", got2, it.ct);
          chk(!extra, "R4 done single pulse", 64'(extra), 64'd0);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R4 watchdog expired actual=%0d expected=%0d", cyc, 200000);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done_o == 1'b0, "R1 done after reset", 64'(done_o), 64'd0);
    chk(dout_o == 1'b0, "R1 output after reset", 64'(dout_o), 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(done_o == 1'b0, "R1 idle done low", 64'(done_o), 64'd0);

    fill_keys(0); run_enc(64'h0, 0, 1'b0);                          // R2 R7 R8
    fill_keys(1); run_enc(64'hFFFF_FFFF_FFFF_FFFF, 0, 1'b0);        // R11 carries
    fill_keys(2); run_enc({$urandom, $urandom}, 37, 1'b0);          // R3 delayed start
    fill_keys(2); run_enc({$urandom, $urandom}, 128, 1'b1);         // R3 R12
    fill_keys(2); run_enc(64'h0123_4567_89AB_CDEF, 5, 1'b0);        // R9 R10

    repeat (50) @(negedge clk);
    chk(sb.size() == 0, "R4 all results delivered", 64'(sb.size()), 64'd0);
    chk(n_done == n_runs, "R12 done count", 64'(n_done), 64'(n_runs));
    summary();
    $finish;
  end
endmodule